// File: doc/BRIEF.md
# Multichannel Serial ADC Scan Sequencer

This block runs an eight-channel, 16-bit successive-approximation converter over a synchronous serial link made of a clock it generates, a command line into the converter, a result line out of it, and a separate busy line. For each conversion it sends an 8-bit command byte. The byte carries a start flag, the channel number, the choice between single-ended and differential input, and a 2-bit power mode. It then waits for the busy line to drop and shifts in the 16-bit result, most significant bit first.

While the input `run` is held high, the block walks a programmable list of channels without gaps. The first bit of the next command byte is placed on the command line so that it is clocked into the converter on the same serial clock edge that captures the last result bit. Each completed result comes out as a one-cycle `sample_valid` strobe together with the 16-bit value and the channel it belongs to. A small write-only configuration port sets the channel list, its length, the mode bits and a busy timeout. If the busy line does not drop in time, the block pulses `timeout` and sends the same command byte again.

The serial clock is the system clock divided by `2*SCLK_HALF`. Choose `SCLK_HALF` so that 24 serial clocks per sample keep the sample rate at or below 100 kHz.

Top module: `adc_scan_sequencer`

## Requirements
- R1: During reset and after it is released, with `run` low, `adc_sclk`, `adc_din`, `sample_valid` and `timeout` are all 0, and the serial clock does not toggle.
- R2: Each command byte is sent MSB first over 8 rising edges of `adc_sclk`. Bit 7 is 1 (start), bits 6:4 are the channel, bit 3 is 0, bit 2 is the single-ended select and bits 1:0 are the power mode. `adc_din` changes only while `adc_sclk` is low, at its falling edge or at frame start.
- R3: After the command byte, the first rising edge at which `adc_busy` is seen low, having been seen high at an earlier rising edge, captures result bit 15. The next 15 rising edges capture bits 14 down to 0. `sample_data` presents these 16 bits, and `sample_valid` is high in the cycle that follows the last capture.
- R4: `sample_chan` is the channel field of the command byte that started that conversion, not the field of the byte being sent alongside its last bit.
- R5: While `run` stays high, the start bit of the next byte is captured on the same rising edge as the current result's LSB. With one busy clock, successive command bytes therefore start exactly 24 serial clocks apart, and each frame spans 25 serial clocks.
- R6: Channel-list entries sit at configuration addresses 0..7 (`cfg_wdata[2:0]`). Bytes use entries 0 up to length−1 in order, then wrap to 0. After reset, entry i holds channel i.
- R7: The list length is at address 8 (`cfg_wdata[3:0]`). A value of 0 acts as 1 and a value above 8 acts as 8. The reset value is 8.
- R8: The mode register is at address 9: `cfg_wdata[2]` is the single-ended select and `cfg_wdata[1:0]` is the power mode. Both are copied into every byte. After reset they are 1 and 2'b11.
- R9: The busy limit is at address 10 (`cfg_wdata[7:0]`, reset value 8, 0 acts as 1). If that many rising edges pass after the command byte without the busy drop of R3, `timeout` pulses for one cycle and no sample is produced. The same command byte is then sent again and the list does not advance.
- R10: When `run` goes low, a conversion whose byte has already started still completes. After that, no new byte is started and `adc_sclk` comes to rest low.
- R11: `sample_valid` and `timeout` are single-cycle pulses, and they are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep scanning while high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_din | output | 1 | Command bit line to the converter |
| adc_dout | input | 1 | Result bit line from the converter |
| adc_busy | input | 1 | Converter busy indication |
| sample_valid | output | 1 | One-cycle strobe for a new result |
| sample_data | output | 16 | Converted result |
| sample_chan | output | 3 | Channel that the result belongs to |
| timeout | output | 1 | One-cycle pulse when busy failed to drop |

## Verification
Two things happen on the same serial clock edge here. The last result bit is captured, and the start bit of the next command byte is clocked into the converter. On that same edge the channel tag has to switch from the old conversion to the new one. The bench provokes this by keeping `run` high across a multi-entry channel list, with a converter model that logs every byte it receives and the rising edge on which that byte started. It judges the outcome by three things: a spacing of exactly 24 edges between byte starts, each sample carrying the data and channel of its own conversion rather than those of the byte sent over its LSB, and the same overlap behaving correctly when `run` drops just after it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CTRL_W = 8;   // command byte length in serial clocks
  localparam int CHAN_W = 3;   // channel field width inside the command byte
  localparam int PD_W   = 2;   // power mode field width

  typedef enum logic [1:0] {
    ST_IDLE,   // serial clock parked or parking low
    ST_CTRL,   // shifting the command byte
    ST_WAIT,   // waiting for the busy drop
    ST_DATA    // shifting the result in
  } seq_state_t;

  // Command byte: start | channel | 0 | single-ended | power mode
  function automatic logic [CTRL_W-1:0] build_ctrl(input logic [CHAN_W-1:0] ch,
                                                   input logic               single,
                                                   input logic [PD_W-1:0]    pmode);
    return {1'b1, ch, 1'b0, single, pmode};
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
// Divides the system clock into the serial clock and flags the cycle
// before each edge so the frame logic can act in step with it.
module adc_sclk_gen #(
  parameter int HALF = 27
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,    // allow new rising edges
  input  logic hold,      // keep the divider at zero while the clock is low
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);

  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DIV_W-1:0] div_q;
  logic             sclk_q;
  logic             tick;

  assign tick      = (div_q == DIV_W'(HALF - 1));
  assign rise_tick = tick && !sclk_q && enable;
  assign fall_tick = tick && sclk_q;
  assign sclk      = sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      if (hold && !sclk_q)
        div_q <= '0;
      else if (tick)
        div_q <= '0;
      else
        div_q <= div_q + DIV_W'(1);

      if (rise_tick)
        sclk_q <= 1'b1;
      else if (fall_tick)
        sclk_q <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_scan_table.sv
// Write-only configuration: channel list, list length, mode bits, busy limit.
module adc_scan_table
  import adc_seq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int CFG_AW = 4,
  parameter int CFG_DW = 16,
  parameter int TMO_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [CFG_AW-1:0]          addr,
  input  logic [CFG_DW-1:0]          wdata,
  input  logic [$clog2(SLOTS)-1:0]   rd_idx,
  output logic [CHAN_W-1:0]          rd_ch,
  output logic [$clog2(SLOTS+1)-1:0] scan_len,
  output logic                       single,
  output logic [PD_W-1:0]            pmode,
  output logic [TMO_W-1:0]           wait_limit
);

  localparam int LEN_W     = $clog2(SLOTS + 1);
  localparam int LEN_ADDR  = SLOTS;
  localparam int MODE_ADDR = SLOTS + 1;
  localparam int TMO_ADDR  = SLOTS + 2;
  localparam int TMO_RST   = 8;

  logic [CHAN_W-1:0] slot_q [SLOTS];
  logic [LEN_W-1:0]  len_q;
  logic              single_q;
  logic [PD_W-1:0]   pmode_q;
  logic [TMO_W-1:0]  limit_q;

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot_q[gi] <= CHAN_W'(gi);
      else if (we && addr == CFG_AW'(gi))
        slot_q[gi] <= wdata[CHAN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= LEN_W'(SLOTS);
      single_q <= 1'b1;
      pmode_q  <= '1;
      limit_q  <= TMO_W'(TMO_RST);
    end else if (we) begin
      if (addr == CFG_AW'(LEN_ADDR))
        len_q <= wdata[LEN_W-1:0];
      if (addr == CFG_AW'(MODE_ADDR)) begin
        single_q <= wdata[PD_W];
        pmode_q  <= wdata[PD_W-1:0];
      end
      if (addr == CFG_AW'(TMO_ADDR))
        limit_q <= wdata[TMO_W-1:0];
    end
  end

  // Clamp the length to 1..SLOTS
  always_comb begin
    if (len_q == '0)
      scan_len = LEN_W'(1);
    else if (len_q > LEN_W'(SLOTS))
      scan_len = LEN_W'(SLOTS);
    else
      scan_len = len_q;
  end

  assign rd_ch      = slot_q[rd_idx];
  assign single     = single_q;
  assign pmode      = pmode_q;
  assign wait_limit = limit_q;

endmodule

// File: rtl/adc_frame_ctrl.sv
// Frame sequencing: command shift, busy wait, result shift, overlap of the
// next command with the result LSB, timeout and retry.
module adc_frame_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int DATA_W = 16,
  parameter int TMO_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run,
  input  logic                       rise_tick,
  input  logic                       fall_tick,
  input  logic                       sclk_lvl,
  input  logic                       busy,
  input  logic                       dout,
  input  logic [CTRL_W-1:0]          ctrl_next,
  input  logic [$clog2(SLOTS+1)-1:0] scan_len,
  input  logic [TMO_W-1:0]           wait_limit,
  output logic [$clog2(SLOTS)-1:0]   idx,
  output logic                       sclk_en,
  output logic                       hold,
  output logic                       din,
  output logic                       valid,
  output logic [DATA_W-1:0]          data,
  output logic [CHAN_W-1:0]          chan,
  output logic                       timeout
);

  localparam int IDX_W = $clog2(SLOTS);
  localparam int CNT_W = $clog2(DATA_W + 1);

  seq_state_t        state_q;
  logic [CTRL_W-1:0] tx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TMO_W-1:0]  wait_q;
  logic              seen_q;
  logic [DATA_W-1:0] rx_q;
  logic [CTRL_W-1:0] cur_q;
  logic [CTRL_W-1:0] pend_q;
  logic              have_pend_q;
  logic              retry_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  idx_nxt;
  logic              limit_hit;
  logic [CTRL_W-1:0] start_byte;

  assign idx_nxt   = (int'(idx_q) + 1 >= int'(scan_len)) ? '0 : idx_q + IDX_W'(1);
  assign limit_hit = ({1'b0, wait_q} + {{TMO_W{1'b0}}, 1'b1}) >= {1'b0, wait_limit};
  assign start_byte = retry_q ? cur_q : ctrl_next;

  assign idx     = idx_q;
  assign sclk_en = (state_q != ST_IDLE);
  assign hold    = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      tx_q        <= '0;
      cnt_q       <= '0;
      wait_q      <= '0;
      seen_q      <= 1'b0;
      rx_q        <= '0;
      cur_q       <= '0;
      pend_q      <= '0;
      have_pend_q <= 1'b0;
      retry_q     <= 1'b0;
      idx_q       <= '0;
      din         <= 1'b0;
      valid       <= 1'b0;
      data        <= '0;
      chan        <= '0;
      timeout     <= 1'b0;
    end else begin
      valid   <= 1'b0;
      timeout <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          // start only once the clock is parked low
          if (run && !sclk_lvl) begin
            cur_q   <= start_byte;
            din     <= start_byte[CTRL_W-1];
            tx_q    <= {start_byte[CTRL_W-2:0], 1'b0};
            if (!retry_q)
              idx_q <= idx_nxt;
            retry_q <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_CTRL;
          end
        end

        ST_CTRL: begin
          if (rise_tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(CTRL_W - 1)) begin
              state_q <= ST_WAIT;
              wait_q  <= '0;
              seen_q  <= 1'b0;
            end
          end
          if (fall_tick) begin
            din  <= tx_q[CTRL_W-1];
            tx_q <= {tx_q[CTRL_W-2:0], 1'b0};
          end
        end

        ST_WAIT: begin
          if (fall_tick)
            din <= 1'b0;
          if (rise_tick) begin
            if (seen_q && !busy) begin
              rx_q    <= {rx_q[DATA_W-2:0], dout};
              cnt_q   <= CNT_W'(1);
              state_q <= ST_DATA;
            end else begin
              if (busy)
                seen_q <= 1'b1;
              if (limit_hit) begin
                timeout <= 1'b1;
                retry_q <= 1'b1;
                state_q <= ST_IDLE;
              end else begin
                wait_q <= wait_q + TMO_W'(1);
              end
            end
          end
        end

        ST_DATA: begin
          if (rise_tick) begin
            rx_q  <= {rx_q[DATA_W-2:0], dout};
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              valid <= 1'b1;
              data  <= {rx_q[DATA_W-2:0], dout};
              chan  <= cur_q[CTRL_W-2 -: CHAN_W];
              if (have_pend_q) begin
                // LSB edge also clocked in the next start bit
                cur_q       <= pend_q;
                have_pend_q <= 1'b0;
                cnt_q       <= CNT_W'(1);
                state_q     <= ST_CTRL;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          if (fall_tick) begin
            if (cnt_q == CNT_W'(DATA_W - 1) && run) begin
              pend_q      <= ctrl_next;
              have_pend_q <= 1'b1;
              idx_q       <= idx_nxt;
              din         <= ctrl_next[CTRL_W-1];
              tx_q        <= {ctrl_next[CTRL_W-2:0], 1'b0};
            end else begin
              din <= 1'b0;
            end
          end
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
  import adc_seq_pkg::*;
#(
  parameter int SCLK_HALF = 27,
  parameter int SLOTS     = 8,
  parameter int DATA_W    = 16,
  parameter int CFG_AW    = 4,
  parameter int CFG_DW    = 16,
  parameter int TMO_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic              adc_sclk,
  output logic              adc_din,
  input  logic              adc_dout,
  input  logic              adc_busy,
  output logic              sample_valid,
  output logic [DATA_W-1:0] sample_data,
  output logic [CHAN_W-1:0] sample_chan,
  output logic              timeout
);

  localparam int IDX_W = $clog2(SLOTS);
  localparam int LEN_W = $clog2(SLOTS + 1);

  logic              rise_tick;
  logic              fall_tick;
  logic              sclk_en;
  logic              hold;
  logic [IDX_W-1:0]  idx;
  logic [CHAN_W-1:0] rd_ch;
  logic [LEN_W-1:0]  scan_len;
  logic              single;
  logic [PD_W-1:0]   pmode;
  logic [TMO_W-1:0]  wait_limit;
  logic [CTRL_W-1:0] ctrl_next;

  assign ctrl_next = build_ctrl(rd_ch, single, pmode);

  adc_sclk_gen #(
    .HALF (SCLK_HALF)
  ) u_sclk (
    .clk       (clk),
    .rst       (rst),
    .enable    (sclk_en),
    .hold      (hold),
    .sclk      (adc_sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  adc_scan_table #(
    .SLOTS  (SLOTS),
    .CFG_AW (CFG_AW),
    .CFG_DW (CFG_DW),
    .TMO_W  (TMO_W)
  ) u_table (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .addr       (cfg_addr),
    .wdata      (cfg_wdata),
    .rd_idx     (idx),
    .rd_ch      (rd_ch),
    .scan_len   (scan_len),
    .single     (single),
    .pmode      (pmode),
    .wait_limit (wait_limit)
  );

  adc_frame_ctrl #(
    .SLOTS  (SLOTS),
    .DATA_W (DATA_W),
    .TMO_W  (TMO_W)
  ) u_frame (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .sclk_lvl   (adc_sclk),
    .busy       (adc_busy),
    .dout       (adc_dout),
    .ctrl_next  (ctrl_next),
    .scan_len   (scan_len),
    .wait_limit (wait_limit),
    .idx        (idx),
    .sclk_en    (sclk_en),
    .hold       (hold),
    .din        (adc_din),
    .valid      (sample_valid),
    .data       (sample_data),
    .chan       (sample_chan),
    .timeout    (timeout)
  );

endmodule

// File: rtl/adc_scan_sequencer_chk.sv
module adc_scan_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic adc_sclk,
  input logic adc_din,
  input logic sample_valid,
  input logic timeout
);

  // R2: command line is steady while the serial clock stays high
  a_r2_din_steady_high: assert property (@(posedge clk) disable iff (rst)
    (adc_sclk && $past(adc_sclk)) |-> $stable(adc_din));

  // R11: result strobe lasts one cycle
  a_r11_valid_single: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R9: timeout flag lasts one cycle
  a_r9_timeout_single: assert property (@(posedge clk) disable iff (rst)
    timeout |=> !timeout);

  // R11: a timed-out frame yields no sample
  a_r11_no_valid_on_timeout: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !sample_valid);

  // R3: a result appears just after a rising serial edge
  a_r3_valid_after_rise: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> adc_sclk);

endmodule

bind adc_scan_sequencer adc_scan_sequencer_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .adc_sclk     (adc_sclk),
  .adc_din      (adc_din),
  .sample_valid (sample_valid),
  .timeout      (timeout)
);

// File: tb/test_adc_scan_sequencer.sv
module test_adc_scan_sequencer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        adc_dout;
  logic        adc_busy;
  logic        adc_sclk;
  logic        adc_din;
  logic        sample_valid;
  logic [15:0] sample_data;
  logic [2:0]  sample_chan;
  logic        timeout;

  always #4 clk = ~clk;   // 125 MHz

  adc_scan_sequencer i_adc_scan_sequencer (
    .clk (clk), .rst (rst), .run (run),
    .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
    .adc_sclk (adc_sclk), .adc_din (adc_din), .adc_dout (adc_dout), .adc_busy (adc_busy),
    .sample_valid (sample_valid), .sample_data (sample_data),
    .sample_chan (sample_chan), .timeout (timeout)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int k, input logic [2:0] ch);
    return 16'(k * 16'h3A5D) ^ {ch, ch, ch, ch, ch, 1'b1};
  endfunction

  // ---------------- converter model ----------------
  int          rise_idx;
  logic [7:0]  rx_byte;
  int          rx_cnt;
  int          rx_start;
  logic [7:0]  blog [64];
  int          bstart [64];
  int          nb;
  logic [2:0]  cch [64];
  int          nconv;
  bit          drop_next;
  bit          ctrl_done;
  int          busy_rises;
  int          tx_idx;
  logic [15:0] tx_word;

  always @(posedge adc_sclk or posedge rst) begin
    if (rst) begin
      rise_idx = 0; rx_cnt = 0; rx_byte = '0; rx_start = 0; nb = 0;
      nconv = 0; drop_next = 0; ctrl_done = 0; busy_rises = 0;
    end else begin
      rise_idx++;
      if (rx_cnt == 0) begin
        if (adc_din) begin
          rx_byte = 8'h01; rx_cnt = 1; rx_start = rise_idx;
        end
      end else begin
        rx_byte = {rx_byte[6:0], adc_din};
        rx_cnt++;
        if (rx_cnt == 8) begin
          if (nb < 64) begin
            blog[nb] = rx_byte; bstart[nb] = rx_start;
          end
          nb++;
          rx_cnt = 0;
          if (drop_next) drop_next = 0;
          else ctrl_done = 1;
        end
      end
      if (adc_busy) busy_rises++;
    end
  end

  always @(negedge adc_sclk or posedge rst) begin
    if (rst) begin
      adc_busy = 1'b0; adc_dout = 1'b0; tx_idx = -1; tx_word = '0;
    end else if (ctrl_done) begin
      ctrl_done = 0; adc_busy = 1'b1; busy_rises = 0;
    end else if (adc_busy && busy_rises >= 1) begin
      adc_busy = 1'b0;
      tx_word  = word_of(nconv, rx_byte[6:4]);
      if (nconv < 64) cch[nconv] = rx_byte[6:4];
      nconv++;
      adc_dout = tx_word[15];
      tx_idx   = 14;
    end else if (tx_idx >= 0) begin
      adc_dout = tx_word[tx_idx];
      tx_idx--;
    end else begin
      adc_dout = 1'b0;
    end
  end

  // ---------------- output monitor ----------------
  logic [15:0] sdata [64];
  logic [2:0]  schan [64];
  int          ns;
  int          ntmo;

  always @(negedge clk) begin
    if (rst) begin
      ns = 0; ntmo = 0;
    end else begin
      if (sample_valid) begin
        if (ns < 64) begin
          sdata[ns] = sample_data; schan[ns] = sample_chan;
        end
        ns++;
      end
      if (timeout) ntmo++;
    end
  end

  // ---------------- helpers ----------------
  task automatic do_reset();
    run = 1'b0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_samples(input int n);
    while (ns < n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    do_reset();
    chk(adc_sclk == 1'b0, "R1", "sclk after reset", adc_sclk, 0);
    chk(adc_din == 1'b0, "R1", "din after reset", adc_din, 0);
    chk(sample_valid == 1'b0 && timeout == 1'b0, "R1", "strobes after reset",
        {sample_valid, timeout}, 0);
    repeat (300) @(negedge clk);
    chk(rise_idx == 0, "R1", "no serial clock while run low", rise_idx, 0);
  endtask

  task automatic t_default_scan();
    do_reset();
    run = 1'b1;
    wait_samples(9);
    run = 1'b0;
    for (int k = 0; k < 9; k++) begin
      logic [2:0] ch = 3'(k % 8);
      chk(blog[k] == {1'b1, ch, 1'b0, 1'b1, 2'b11}, "R2", "byte layout (R6, R8 defaults)",
          blog[k], {1'b1, ch, 1'b0, 1'b1, 2'b11});
      chk(sdata[k] == word_of(k, ch), "R3", "result bits", sdata[k], word_of(k, ch));
      chk(schan[k] == ch, "R4", "channel tag", schan[k], ch);
    end
    for (int k = 1; k < 9; k++)
      chk(bstart[k] - bstart[k-1] == 24, "R5", "byte start spacing",
          bstart[k] - bstart[k-1], 24);
    chk(bstart[0] == 1, "R5", "first byte on first edge", bstart[0], 1);
    repeat (4000) @(negedge clk);
    chk(nb == 10, "R10", "bytes after stop", nb, 10);
    chk(ns == 10, "R10", "samples after stop", ns, 10);
    chk(adc_sclk == 1'b0, "R10", "sclk parked low", adc_sclk, 0);
    chk(ntmo == 0, "R11", "no timeouts in clean run", ntmo, 0);
  endtask

  task automatic t_config_scan();
    logic [2:0] lst [3] = '{3'd5, 3'd2, 3'd7};
    do_reset();
    cfg_write(4'd0, 16'd5);
    cfg_write(4'd1, 16'd2);
    cfg_write(4'd2, 16'd7);
    cfg_write(4'd8, 16'd3);
    cfg_write(4'd9, 16'b001);
    run = 1'b1;
    wait_samples(6);
    run = 1'b0;
    for (int k = 0; k < 6; k++) begin
      logic [2:0] ch = lst[k % 3];
      chk(blog[k] == {1'b1, ch, 1'b0, 1'b0, 2'b01}, "R6", "list order and mode (R7, R8)",
          blog[k], {1'b1, ch, 1'b0, 1'b0, 2'b01});
      chk(schan[k] == ch, "R4", "tag follows own byte", schan[k], ch);
      chk(sdata[k] == word_of(k, ch), "R3", "result bits", sdata[k], word_of(k, ch));
    end
    repeat (4000) @(negedge clk);
  endtask

  task automatic t_len_zero();
    do_reset();
    cfg_write(4'd0, 16'd6);
    cfg_write(4'd8, 16'd0);
    run = 1'b1;
    wait_samples(3);
    run = 1'b0;
    for (int k = 0; k < 3; k++)
      chk(blog[k][6:4] == 3'd6, "R7", "zero length acts as one", blog[k][6:4], 6);
    repeat (4000) @(negedge clk);
    do_reset();
    cfg_write(4'd8, 16'd12);
    run = 1'b1;
    wait_samples(9);
    run = 1'b0;
    chk(blog[8][6:4] == 3'd0, "R7", "oversize length wraps at 8", blog[8][6:4], 0);
    repeat (4000) @(negedge clk);
  endtask

  task automatic t_timeout();
    do_reset();
    cfg_write(4'd10, 16'd5);
    drop_next = 1;
    run = 1'b1;
    wait_samples(2);
    run = 1'b0;
    chk(ntmo == 1, "R9", "one timeout pulse", ntmo, 1);
    chk(blog[1] == blog[0], "R9", "same byte resent", blog[1], blog[0]);
    chk(blog[2][6:4] == 3'd1, "R9", "list did not skip", blog[2][6:4], 1);
    chk(schan[0] == 3'd0 && sdata[0] == word_of(0, 3'd0), "R9", "retried result",
        sdata[0], word_of(0, 3'd0));
    chk(ns == nconv || ns + 1 == nconv, "R11", "no sample for lost frame", ns, nconv);
    repeat (4000) @(negedge clk);
    chk(ns == nconv, "R11", "samples match conversions", ns, nconv);
  endtask

  initial begin
    t_reset_state();
    t_default_scan();
    t_config_scan();
    t_len_zero();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule